// File: doc/BRIEF.md
# Paced Dual-Channel Serial ADC Batch Capture

This block reads two external serial converters at a fixed sample rate and stores the results in memory for a consumer. A free-running sample counter sets the rate. For each conversion the block pulls a channel's active-low convert/select line low and waits a programmable setup time. It then clocks sixteen bits in from that channel's serial data input and writes the two's-complement word into the buffer half that the channel is currently filling.

In each sample period the counter first clears every channel's end-of-transfer status, at count 0. It then starts channel c at count 2 + c, so the two captures are one cycle apart and never land on the same cycle. Each channel has two buffers of N words. When the buffer being filled is full, it becomes the readable one and capture carries on into the other buffer without a gap. Channel 0 alone signals each completed batch with a one-cycle pulse.

The consumer reads the completed words through an address port and hands the buffer back with a release pulse. If the next batch completes while the previous one has not been handed back, a sticky overflow flag reports that samples were lost. In that case the oldest buffer is the one overwritten.

Top module: `adc_batch_capture`

## Requirements
- R1: After reset both select lines are high, both serial clocks are low, and batchReady and overflow are 0.
- R2: While runEn is low no select line falls. periodCfg and setupCfg may be changed in that state and take effect when runEn rises.
- R3: While running, the sample counter steps 0 to periodCfg-1 and wraps. Conversions on a channel start periodCfg cycles apart, and channel 1's select line falls exactly one cycle after channel 0's.
- R4: After a select line falls, the serial clock stays low and its first rising edge comes exactly setupCfg + 1 + SCLK_HALF cycles later.
- R5: Each conversion gives 16 serial clock pulses, each phase lasting SCLK_HALF cycles. The data input is sampled at each rising edge, most significant bit first. The select line goes high on the edge that ends the 16th pulse, and the serial clock is low whenever the select line is high.
- R6: Sample k of channel c goes to index k mod BATCH_LEN of that channel's active half, and the halves swap after index BATCH_LEN-1, so no sample is skipped. rdData returns word rdAddr of the last completed half of channel rdCh (0 or 1), as a 16-bit two's-complement code.
- R7: batchReady is a one-cycle pulse, raised in the cycle after channel 0 completes the last word of a batch, once per channel-0 batch.
- R8: A channel's done status is set when a conversion ends and cleared at count 0. A start at count 2 + c is taken only if the channel is idle and its status is clear, and a start that arrives while the channel is busy is dropped. As a result, a period shorter than one conversion gives starts 2*periodCfg apart.
- R9: overflow is set when a batch completes while the previous batch has not been released by a bufRelease pulse. The new batch is still handed over, and it overwrites the oldest buffer.
- R10: overflow stays set until ovfClear is pulsed. If a set and a clear happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | Runs the sample counter; low holds it at 0 |
| periodCfg | input | PER_W | Sample period in clock cycles |
| setupCfg | input | SETUP_W | Extra setup cycles after a select line falls |
| adcCsN | output | 2 | Active-low convert/select line, one per channel |
| adcSclk | output | 2 | Serial clock, one per channel |
| adcMiso | input | 2 | Serial data from each converter |
| rdCh | input | 1 | Channel selected for reading |
| rdAddr | input | clog2(BATCH_LEN) | Word index within the completed half |
| rdData | output | 16 | Two's-complement word read |
| batchReady | output | 1 | One-cycle pulse per completed batch |
| bufRelease | input | 1 | Pulse that returns the handed-over buffer |
| overflow | output | 1 | Sticky flag for a lost batch |
| ovfClear | input | 1 | Clears overflow |

## Verification
The assertions watch the serial timing on every cycle. They confirm that a select line never falls unless the counter was running, that the setup gap comes before any clock pulse, that each select window holds exactly sixteen pulses, and that the clock is idle while deselected. They also confirm that batchReady lasts one cycle, that overflow rises only together with a batch handover, and that overflow stays set until cleared. Only the bench scenarios can show the exact period and skew between channels, the bit order and data contents across the buffer swap, and the doubled period when a start meets a busy channel. The bench also covers the overflow sequence with an unreleased buffer and the carrying over of settings loaded while stopped.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int CH_NUM    = 2;
  localparam int SAMPLE_W  = 16;
  localparam int BIT_CNT_W = $clog2(SAMPLE_W + 1);

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SETUP = 2'd1,
    RX_SHIFT = 2'd2
  } rxState_e;

  // Strobes and selects from the control to the datapath
  typedef struct packed {
    logic [CH_NUM-1:0] clrDone;  // clear end-of-transfer status
    logic [CH_NUM-1:0] trig;     // start a conversion
    logic [CH_NUM-1:0] wrHalf;   // half currently being filled
  } capStrobe_t;
endpackage

// File: rtl/adc_serial_rx.sv
module adc_serial_rx
  import adc_cap_pkg::*;
#(
  parameter int SETUP_W   = 8,
  parameter int SCLK_HALF = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trig,
  input  logic                clrDone,
  input  logic [SETUP_W-1:0]  setupCfg,
  input  logic                miso,
  output logic                csN,
  output logic                sclk,
  output logic                wordDone,
  output logic [SAMPLE_W-1:0] word
);
  localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

  rxState_e              state;
  logic [SETUP_W-1:0]    setupCnt;
  logic [DIV_W-1:0]      divCnt;
  logic [BIT_CNT_W-1:0]  bitCnt;
  logic [SAMPLE_W-1:0]   shiftReg;
  logic                  doneFlag;
  logic                  halfEnd;
  logic                  startOk;
  logic                  finish;

  assign halfEnd = (divCnt == DIV_W'(SCLK_HALF - 1));
  assign startOk = trig && (state == RX_IDLE) && !doneFlag;
  assign finish  = (state == RX_SHIFT) && halfEnd && sclk &&
                   (bitCnt == BIT_CNT_W'(SAMPLE_W));
  assign word    = shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
    end else if (finish) begin
      doneFlag <= 1'b1;
    end else if (clrDone) begin
      doneFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= RX_IDLE;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      setupCnt <= '0;
      divCnt   <= '0;
      bitCnt   <= '0;
      shiftReg <= '0;
      wordDone <= 1'b0;
    end else begin
      wordDone <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (startOk) begin
            csN      <= 1'b0;
            setupCnt <= '0;
            state    <= RX_SETUP;
          end
        end
        RX_SETUP: begin
          if (setupCnt == setupCfg) begin
            state  <= RX_SHIFT;
            divCnt <= '0;
            bitCnt <= '0;
          end else begin
            setupCnt <= setupCnt + 1'b1;
          end
        end
        RX_SHIFT: begin
          if (halfEnd) begin
            divCnt <= '0;
            if (!sclk) begin
              sclk     <= 1'b1;
              shiftReg <= {shiftReg[SAMPLE_W-2:0], miso};
              bitCnt   <= bitCnt + 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bitCnt == BIT_CNT_W'(SAMPLE_W)) begin
                csN      <= 1'b1;
                state    <= RX_IDLE;
                wordDone <= 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_cap_ctrl.sv
module adc_cap_ctrl
  import adc_cap_pkg::*;
#(
  parameter int BATCH_LEN = 4,
  parameter int PER_W     = 16,
  parameter int IDX_W     = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           runEn,
  input  logic [PER_W-1:0]               periodCfg,
  input  logic                           bufRelease,
  input  logic                           ovfClear,
  input  logic [CH_NUM-1:0]              wordDone,
  output capStrobe_t                     ctl,
  output logic [CH_NUM-1:0][IDX_W-1:0]   wrIdx,
  output logic                           batchReady,
  output logic                           overflow
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BATCH_LEN - 1);

  logic [PER_W-1:0]  sampleCnt;
  logic [PER_W:0]    nextCnt;
  logic              wrapNow;
  logic [CH_NUM-1:0] halfQ;
  logic              held;
  logic              fillMain;

  assign nextCnt = {1'b0, sampleCnt} + 1'b1;
  assign wrapNow = (nextCnt >= {1'b0, periodCfg});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCnt <= '0;
    end else if (!runEn || wrapNow) begin
      sampleCnt <= '0;
    end else begin
      sampleCnt <= nextCnt[PER_W-1:0];
    end
  end

  always_comb begin
    for (int c = 0; c < CH_NUM; c++) begin
      ctl.clrDone[c] = runEn && (sampleCnt == '0);
      ctl.trig[c]    = runEn && (sampleCnt == PER_W'(2 + c));
      ctl.wrHalf[c]  = halfQ[c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfQ <= '0;
      wrIdx <= '0;
    end else begin
      for (int c = 0; c < CH_NUM; c++) begin
        if (wordDone[c]) begin
          if (wrIdx[c] == LAST_IDX) begin
            wrIdx[c] <= '0;
            halfQ[c] <= ~halfQ[c];
          end else begin
            wrIdx[c] <= wrIdx[c] + 1'b1;
          end
        end
      end
    end
  end

  assign fillMain = wordDone[0] && (wrIdx[0] == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      batchReady <= 1'b0;
      held       <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      batchReady <= fillMain;
      if (fillMain) begin
        held <= 1'b1;
      end else if (bufRelease) begin
        held <= 1'b0;
      end
      if (fillMain && held && !bufRelease) begin
        overflow <= 1'b1;
      end else if (ovfClear) begin
        overflow <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_cap_datapath.sv
module adc_cap_datapath
  import adc_cap_pkg::*;
#(
  parameter int BATCH_LEN = 4,
  parameter int SETUP_W   = 8,
  parameter int SCLK_HALF = 2,
  parameter int IDX_W     = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  capStrobe_t                   ctl,
  input  logic [CH_NUM-1:0][IDX_W-1:0] wrIdx,
  input  logic [SETUP_W-1:0]           setupCfg,
  input  logic [CH_NUM-1:0]            adcMiso,
  input  logic                         rdCh,
  input  logic [IDX_W-1:0]             rdAddr,
  output logic [CH_NUM-1:0]            adcCsN,
  output logic [CH_NUM-1:0]            adcSclk,
  output logic [CH_NUM-1:0]            wordDone,
  output logic [SAMPLE_W-1:0]          rdData
);
  logic [SAMPLE_W-1:0] chRead [CH_NUM];
  logic                addrOk;

  assign addrOk = (32'(rdAddr) < BATCH_LEN);

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    logic [SAMPLE_W-1:0] rxWord;
    logic [SAMPLE_W-1:0] bufMem [2][BATCH_LEN];

    adc_serial_rx #(
      .SETUP_W  (SETUP_W),
      .SCLK_HALF(SCLK_HALF)
    ) rx_i (
      .clk     (clk),
      .rstN    (rstN),
      .trig    (ctl.trig[c]),
      .clrDone (ctl.clrDone[c]),
      .setupCfg(setupCfg),
      .miso    (adcMiso[c]),
      .csN     (adcCsN[c]),
      .sclk    (adcSclk[c]),
      .wordDone(wordDone[c]),
      .word    (rxWord)
    );

    always_ff @(posedge clk) begin
      if (wordDone[c]) begin
        bufMem[ctl.wrHalf[c]][wrIdx[c]] <= rxWord;
      end
    end

    assign chRead[c] = addrOk ? bufMem[~ctl.wrHalf[c]][rdAddr] : '0;
  end

  assign rdData = chRead[rdCh];
endmodule

// File: rtl/adc_batch_capture.sv
module adc_batch_capture
  import adc_cap_pkg::*;
#(
  parameter int BATCH_LEN = 4,
  parameter int PER_W     = 16,
  parameter int SETUP_W   = 8,
  parameter int SCLK_HALF = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         runEn,
  input  logic [PER_W-1:0]             periodCfg,
  input  logic [SETUP_W-1:0]           setupCfg,
  output logic [1:0]                   adcCsN,
  output logic [1:0]                   adcSclk,
  input  logic [1:0]                   adcMiso,
  input  logic                         rdCh,
  input  logic [$clog2(BATCH_LEN)-1:0] rdAddr,
  output logic [15:0]                  rdData,
  output logic                         batchReady,
  input  logic                         bufRelease,
  output logic                         overflow,
  input  logic                         ovfClear
);
  localparam int IDX_W = $clog2(BATCH_LEN);

  capStrobe_t                   ctl;
  logic [CH_NUM-1:0][IDX_W-1:0] wrIdx;
  logic [CH_NUM-1:0]            wordDone;

  adc_cap_ctrl #(
    .BATCH_LEN(BATCH_LEN),
    .PER_W    (PER_W),
    .IDX_W    (IDX_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .periodCfg (periodCfg),
    .bufRelease(bufRelease),
    .ovfClear  (ovfClear),
    .wordDone  (wordDone),
    .ctl       (ctl),
    .wrIdx     (wrIdx),
    .batchReady(batchReady),
    .overflow  (overflow)
  );

  adc_cap_datapath #(
    .BATCH_LEN(BATCH_LEN),
    .SETUP_W  (SETUP_W),
    .SCLK_HALF(SCLK_HALF),
    .IDX_W    (IDX_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .wrIdx   (wrIdx),
    .setupCfg(setupCfg),
    .adcMiso (adcMiso),
    .rdCh    (rdCh),
    .rdAddr  (rdAddr),
    .adcCsN  (adcCsN),
    .adcSclk (adcSclk),
    .wordDone(wordDone),
    .rdData  (rdData)
  );
endmodule

// File: rtl/adc_batch_capture_chk.sv
module adc_batch_capture_chk #(
  parameter int SETUP_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               runEn,
  input logic [SETUP_W-1:0] setupCfg,
  input logic [1:0]         adcCsN,
  input logic [1:0]         adcSclk,
  input logic               batchReady,
  input logic               overflow,
  input logic               ovfClear
);
  localparam int GAP_W = SETUP_W + 2;

  for (genvar c = 0; c < 2; c++) begin : g_mon
    logic [GAP_W-1:0] sinceFall;
    logic [5:0]       pulseCnt;
    logic             sclkQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sinceFall <= '0;
        pulseCnt  <= '0;
        sclkQ     <= 1'b0;
      end else begin
        sclkQ <= adcSclk[c];
        if (adcCsN[c]) begin
          sinceFall <= '0;
          pulseCnt  <= '0;
        end else begin
          if (sinceFall != '1) sinceFall <= sinceFall + 1'b1;
          if (adcSclk[c] && !sclkQ) pulseCnt <= pulseCnt + 1'b1;
        end
      end
    end

    // R2: a conversion only starts while the counter runs
    p_start_gated_r2: assert property (@(posedge clk) disable iff (!rstN)
      $fell(adcCsN[c]) |-> $past(runEn));

    // R4: setup gap before the first clock pulse
    p_setup_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(adcSclk[c]) |-> (sinceFall >= (GAP_W'(setupCfg) + 1'b1)));

    // R5: serial clock idle while deselected
    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
      adcCsN[c] |-> !adcSclk[c]);

    // R5: sixteen pulses per select window
    p_bit_count_r5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(adcCsN[c]) |-> (pulseCnt == 6'd16));
  end

  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    batchReady |=> !batchReady);

  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> batchReady);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !ovfClear) |=> overflow);

  p_ovf_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    ovfClear |=> (!overflow || batchReady));
endmodule

bind adc_batch_capture adc_batch_capture_chk #(.SETUP_W(SETUP_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .runEn     (runEn),
  .setupCfg  (setupCfg),
  .adcCsN    (adcCsN),
  .adcSclk   (adcSclk),
  .batchReady(batchReady),
  .overflow  (overflow),
  .ovfClear  (ovfClear)
);

// File: tb/adc_batch_capture_tb_top.sv
module adc_batch_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BATCH_LEN  = 4;
  localparam int SCLK_HALF  = 2;

  logic        clk = 1'b0;
  logic        rstN;
  logic        runEn;
  logic [15:0] periodCfg;
  logic [7:0]  setupCfg;
  logic [1:0]  adcCsN;
  logic [1:0]  adcSclk;
  logic [1:0]  adcMiso;
  logic        rdCh;
  logic [1:0]  rdAddr;
  logic [15:0] rdData;
  logic        batchReady;
  logic        bufRelease;
  logic        overflow;
  logic        ovfClear;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_batch_capture dut_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .periodCfg(periodCfg),
    .setupCfg(setupCfg), .adcCsN(adcCsN), .adcSclk(adcSclk),
    .adcMiso(adcMiso), .rdCh(rdCh), .rdAddr(rdAddr), .rdData(rdData),
    .batchReady(batchReady), .bufRelease(bufRelease),
    .overflow(overflow), .ovfClear(ovfClear)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [15:0] genWord(input int c, input int k);
    logic [15:0] v;
    v = 16'((k + 1) * 16'h3b57 + c * 16'h71c9);
    return v ^ ((c == 0) ? 16'hf00f : 16'h0f0f);
  endfunction

  // Scoreboard queues filled by the converter model
  logic [15:0] expQ0[$];
  logic [15:0] expQ1[$];

  int  cyc = 0;
  int  expInterval = 100;
  int  readyCnt = 0;
  int  totalFalls = 0;
  bit  skipRelease = 1'b0;

  // Converter model and timing monitor
  initial begin
    bit          prevCs[2];
    bit          prevSclk[2];
    bit          fallValid[2];
    bit          prevReady;
    int          fallT[2];
    int          pulses[2];
    int          ptr[2];
    int          sampK[2];
    int          doneCnt[2];
    logic [15:0] curWord[2];
    adcMiso = 2'b00;
    prevReady = 1'b0;
    for (int c = 0; c < 2; c++) begin
      prevCs[c] = 1'b1; prevSclk[c] = 1'b0; fallValid[c] = 1'b0;
      fallT[c] = 0; pulses[c] = 0; ptr[c] = -1; sampK[c] = 0;
      doneCnt[c] = 0; curWord[c] = '0;
    end
    forever begin
      @(negedge clk);
      cyc++;
      if (rstN) begin
        for (int c = 0; c < 2; c++) begin
          if (!runEn) fallValid[c] = 1'b0;
          if (prevCs[c] && !adcCsN[c]) begin
            totalFalls++;
            if (fallValid[c])
              chk((cyc - fallT[c]) == expInterval, "R3/R8 start interval", cyc - fallT[c], expInterval);
            if (c == 1)
              chk((cyc - fallT[0]) == 1, "R3 channel skew", cyc - fallT[0], 1);
            fallT[c] = cyc; fallValid[c] = 1'b1; pulses[c] = 0;
            curWord[c] = genWord(c, sampK[c]);
            sampK[c]++;
            if (c == 0) expQ0.push_back(curWord[c]); else expQ1.push_back(curWord[c]);
            adcMiso[c] = curWord[c][15];
            ptr[c] = 14;
          end
          if (!adcCsN[c] && !prevSclk[c] && adcSclk[c]) begin
            if (pulses[c] == 0)
              chk((cyc - fallT[c]) == int'(setupCfg) + 1 + SCLK_HALF, "R4 setup gap",
                  cyc - fallT[c], int'(setupCfg) + 1 + SCLK_HALF);
            pulses[c]++;
          end
          if (!adcCsN[c] && prevSclk[c] && !adcSclk[c] && ptr[c] >= 0) begin
            adcMiso[c] = curWord[c][ptr[c]];
            ptr[c]--;
          end
          if (!prevCs[c] && adcCsN[c]) begin
            chk(pulses[c] == 16, "R5 pulses per conversion", pulses[c], 16);
            chk(!adcSclk[c], "R5 clock low when deselected", int'(adcSclk[c]), 0);
            doneCnt[c]++;
          end
          prevCs[c] = adcCsN[c];
          prevSclk[c] = adcSclk[c];
        end
        if (batchReady) begin
          chk(!prevReady, "R7 pulse width", int'(prevReady), 0);
          chk((doneCnt[0] % BATCH_LEN) == 0, "R7 batch boundary", doneCnt[0] % BATCH_LEN, 0);
          readyCnt++;
        end
        prevReady = batchReady;
      end
    end
  end

  // Scoreboard monitor: reads each completed batch and compares
  initial begin
    logic [15:0] exp;
    rdCh = 1'b0; rdAddr = '0; bufRelease = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN && batchReady) begin
        repeat (4) @(negedge clk);
        for (int ch = 0; ch < 2; ch++) begin
          for (int a = 0; a < BATCH_LEN; a++) begin
            rdCh = ch[0];
            rdAddr = a[1:0];
            #1;
            if ((ch == 0 && expQ0.size() == 0) || (ch == 1 && expQ1.size() == 0)) begin
              chk(1'b0, "R6 expected word missing", int'(rdData), -1);
            end else begin
              exp = (ch == 0) ? expQ0.pop_front() : expQ1.pop_front();
              chk(rdData == exp, "R6 batch word", int'(rdData), int'(exp));
            end
            @(negedge clk);
          end
        end
        if (skipRelease) begin
          skipRelease = 1'b0;
        end else begin
          bufRelease = 1'b1;
          @(negedge clk);
          bufRelease = 1'b0;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    finishRun();
  end

  // Main sequence
  initial begin
    rstN = 1'b0; runEn = 1'b0; periodCfg = 16'd7; setupCfg = 8'd9; ovfClear = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(adcCsN == 2'b11, "R1 select lines high", int'(adcCsN), 3);
    chk(adcSclk == 2'b00, "R1 serial clocks low", int'(adcSclk), 0);
    chk(!batchReady, "R1 batchReady low", int'(batchReady), 0);
    chk(!overflow, "R1 overflow low", int'(overflow), 0);

    // R2: stopped, configuration loaded meanwhile
    repeat (150) @(negedge clk);
    periodCfg = 16'd100; setupCfg = 8'd3; expInterval = 100;
    repeat (150) @(negedge clk);
    chk(totalFalls == 0, "R2 no conversion while stopped", totalFalls, 0);

    runEn = 1'b1;
    wait (readyCnt == 3);
    repeat (3) @(negedge clk);
    chk(!overflow, "R9 no overflow with releases", int'(overflow), 0);
    skipRelease = 1'b1;  // batch 3 stays held

    wait (readyCnt == 4);
    repeat (2) @(negedge clk);
    chk(overflow, "R9 overflow on unreleased batch", int'(overflow), 1);

    wait (readyCnt == 5);
    repeat (2) @(negedge clk);
    chk(overflow, "R10 overflow sticky", int'(overflow), 1);
    ovfClear = 1'b1;
    @(negedge clk);
    ovfClear = 1'b0;
    @(negedge clk);
    chk(!overflow, "R10 overflow cleared", int'(overflow), 0);

    // R8: period shorter than a conversion, zero setup
    wait (readyCnt == 6);
    repeat (3) @(negedge clk);
    runEn = 1'b0;
    periodCfg = 16'd40; setupCfg = 8'd0; expInterval = 80;
    repeat (20) @(negedge clk);
    runEn = 1'b1;
    wait (readyCnt == 8);
    repeat (3) @(negedge clk);
    runEn = 1'b0;
    repeat (60) @(negedge clk);
    chk(expQ0.size() == 0, "R6 channel 0 words all read", expQ0.size(), 0);
    chk(expQ1.size() == 0, "R6 channel 1 words all read", expQ1.size(), 0);
    chk(!overflow, "R10 overflow stays clear", int'(overflow), 0);
    finishRun();
  end
endmodule